// File: doc/BRIEF.md
# Receive DMA Process Controller

This block is the control sequencer of a descriptor-ring receive DMA engine. A level control bit (`run_bit`) starts and stops the receive process. The process moves between four states: Stopped, Running-fetch (reading a descriptor's ownership flag), Running-wait-frame (holding an owned descriptor while the receiver fills it) and Suspended (the fetched descriptor was still owned by software). The block keeps the current descriptor pointer. The first start loads the pointer from a programmable base address. A later stop keeps it, and the following start resumes from that point.

Descriptors are read through a simple request/acknowledge port. The fetch address is the current pointer. Along with the acknowledge come the ownership flag and an end-of-ring marker. When the receiver signals the end of a frame, the pointer moves forward by one descriptor, or it wraps to the base address after the descriptor that carries the end-of-ring marker. A stop request takes effect only when the receiver is disabled, and it waits for any frame in progress to finish. A poll kick (a poll demand or a new frame arriving) makes a Suspended process fetch the same descriptor again.

Transitions: Stopped→fetch on start. Fetch→wait-frame when the descriptor is owned. Fetch→Suspended when it is not owned. Wait-frame→fetch at frame end. Suspended→fetch on a kick. Any running state→Stopped on an accepted stop.

Top module: `rxdma_proc_ctrl`

## Requirements
- R1: After reset the state code is 0 (Stopped), the pointer is 0, every status bit is 0 and no fetch is requested.
- R2: In Stopped with `run_bit`=1, the next cycle shows state code 1 (fetch) and `fetch_req`=1. On the first start after reset, the pointer equals `base_addr`.
- R3: A later start resumes from the pointer kept at the last stop and ignores `base_addr`.
- R4: An acknowledge whose ownership flag is 0, with no stop pending, moves the process to state code 4 (Suspended) and sets status bit 7 (buffer unavailable).
- R5: An acknowledge with the ownership flag set moves the process to state code 2. At `frame_done`, the pointer advances by 16 bytes, or loads `base_addr` if that descriptor had its end-of-ring flag set. With no stop pending, the process then returns to state code 1.
- R6: In state code 2, a stop request does not take effect while `frame_active`=1 and `frame_done`=0. The stop completes at `frame_done`, and the kept pointer is the next descriptor.
- R7: A stop request is `run_bit`=0 together with `rx_enable`=0. While `rx_enable`=1 the process never enters Stopped and status bit 1 does not set. A start command in any state other than Stopped has no effect.
- R8: Entering Stopped from any other state sets status bit 1 (process stopped) in the same cycle, and the pointer is unchanged when the stop comes from fetch or Suspended.
- R9: In Suspended, a `poll_kick` pulse returns the process to state code 1 at the same pointer, so the same descriptor is fetched again.
- R10: Status bits are cleared by writing 1 to the matching bit of `sts_clr`. A set and a clear of the same bit in one cycle leave the bit set.
- R11: A fetch request stays asserted with a stable address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_bit | input | 1 | Start (1) / stop (0) control level |
| rx_enable | input | 1 | Receiver enable; while 1, stop requests are held off |
| base_addr | input | AW | Ring base address |
| frame_active | input | 1 | Receiver is transferring a frame |
| frame_done | input | 1 | One-cycle pulse at the end of a frame |
| poll_kick | input | 1 | Poll demand or new-frame pulse; wakes Suspended |
| fetch_req | output | 1 | Descriptor ownership read request |
| fetch_ack | input | 1 | Read response valid |
| fetch_own | input | 1 | Ownership flag in the response (1 = DMA owns) |
| fetch_eor | input | 1 | End-of-ring flag in the response |
| desc_ptr | output | AW | Current descriptor pointer, also the fetch address |
| proc_state | output | 3 | State code: 0 Stopped, 1 fetch, 2 wait-frame, 4 Suspended |
| sts_word | output | 8 | Sticky status; bit 7 buffer unavailable, bit 1 process stopped |
| sts_clr | input | 8 | Write-one-to-clear strobe for `sts_word` |

## Verification
The assertions check on every cycle that a fetch request holds its address until acknowledged, that a stop never lands while the receiver is enabled or in the middle of a frame, that a refused descriptor leads to Suspended, that the pointer steps or wraps correctly at frame end, and that set-beats-clear holds for each status bit. Only the bench's scenarios can show the longer stories: a stop and restart that resumes from the kept position while a new base address is ignored, a re-fetch of the same descriptor after a poll kick, a wrap that picks up a changed base address, and a start command that has no effect while the process is Suspended.

// File: rtl/rxdma_ctl_pkg.sv
package rxdma_ctl_pkg;

    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SUSP  = 3'd4
    } rxp_state_e;

    localparam int STS_W       = 8;
    localparam int STS_RBU_BIT = 7;
    localparam int STS_RPS_BIT = 1;

endpackage

// File: rtl/rxdma_ptr_unit.sv
module rxdma_ptr_unit #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_req,
    input  logic          adv_req,
    input  logic          wrap_req,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] ptr_q
);
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic seeded_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            seeded_q <= 1'b0;
        end else if (seed_req) begin
            if (!seeded_q) begin
                ptr_q    <= base_addr;
                seeded_q <= 1'b1;
            end
        end else if (adv_req) begin
            ptr_q <= wrap_req ? base_addr : ptr_q + STEP;
        end
    end

endmodule

// File: rtl/rxdma_seq_fsm.sv
module rxdma_seq_fsm
    import rxdma_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_bit,
    input  logic       rx_enable,
    input  logic       frame_active,
    input  logic       frame_done,
    input  logic       poll_kick,
    input  logic       fetch_ack,
    input  logic       fetch_own,
    input  logic       fetch_eor,
    output rxp_state_e state_q,
    output logic       fetch_req,
    output logic       seed_req,
    output logic       adv_req,
    output logic       wrap_req,
    output logic       rbu_set,
    output logic       rps_set
);
    rxp_state_e nxt;
    logic       eor_q;
    logic       stop_req;

    assign stop_req = !run_bit && !rx_enable;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_STOP:  if (run_bit) nxt = ST_FETCH;
            ST_FETCH: begin
                if (fetch_ack) begin
                    if (stop_req)       nxt = ST_STOP;
                    else if (fetch_own) nxt = ST_WAIT;
                    else                nxt = ST_SUSP;
                end
            end
            ST_WAIT: begin
                if (frame_done)                    nxt = stop_req ? ST_STOP : ST_FETCH;
                else if (stop_req && !frame_active) nxt = ST_STOP;
            end
            ST_SUSP: begin
                if (stop_req)       nxt = ST_STOP;
                else if (poll_kick) nxt = ST_FETCH;
            end
            default: nxt = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            eor_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_FETCH && fetch_ack && fetch_own) eor_q <= fetch_eor;
        end
    end

    always_comb begin
        fetch_req = (state_q == ST_FETCH);
        seed_req  = (state_q == ST_STOP) && run_bit;
        adv_req   = (state_q == ST_WAIT) && frame_done;
        wrap_req  = eor_q;
        rbu_set   = (state_q == ST_FETCH) && fetch_ack && !fetch_own && !stop_req;
        rps_set   = (nxt == ST_STOP) && (state_q != ST_STOP);
    end

    // R7: with the receiver enabled, a running process stays out of Stopped
    p_no_stop_rxen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STOP && rx_enable) |=> state_q != ST_STOP);

    // R6: a frame in flight holds off the stop
    p_defer_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && frame_active && !frame_done) |=> state_q == ST_WAIT);

    // R4: a refused descriptor suspends the process
    p_refuse_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && fetch_ack && !fetch_own && (run_bit || rx_enable))
        |=> state_q == ST_SUSP);

endmodule

// File: rtl/rxdma_sticky_status.sv
module rxdma_sticky_status #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_vec,
    input  logic [SW-1:0] clr_vec,
    output logic [SW-1:0] sts_q
);
    for (genvar i = 0; i < SW; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          sts_q[i] <= 1'b0;
            else if (set_vec[i]) sts_q[i] <= 1'b1;
            else if (clr_vec[i]) sts_q[i] <= 1'b0;
        end

        // R10: set beats a simultaneous clear
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> sts_q[i]);

        // R10: a lone write-one clears the bit
        p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !sts_q[i]);
    end

endmodule

// File: rtl/rxdma_proc_ctrl.sv
module rxdma_proc_ctrl
    import rxdma_ctl_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_bit,
    input  logic          rx_enable,
    input  logic [AW-1:0] base_addr,
    input  logic          frame_active,
    input  logic          frame_done,
    input  logic          poll_kick,
    output logic          fetch_req,
    input  logic          fetch_ack,
    input  logic          fetch_own,
    input  logic          fetch_eor,
    output logic [AW-1:0] desc_ptr,
    output logic [2:0]    proc_state,
    output logic [7:0]    sts_word,
    input  logic [7:0]    sts_clr
);
    rxp_state_e        state_q;
    logic              seed_req, adv_req, wrap_req, rbu_set, rps_set;
    logic [STS_W-1:0]  set_vec;

    rxdma_seq_fsm u_fsm (
        .clk, .rst_n, .run_bit, .rx_enable, .frame_active, .frame_done,
        .poll_kick, .fetch_ack, .fetch_own, .fetch_eor,
        .state_q, .fetch_req, .seed_req, .adv_req, .wrap_req, .rbu_set, .rps_set
    );

    rxdma_ptr_unit #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk, .rst_n, .seed_req, .adv_req, .wrap_req, .base_addr, .ptr_q(desc_ptr)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[STS_RBU_BIT] = rbu_set;
        set_vec[STS_RPS_BIT] = rps_set;
    end

    rxdma_sticky_status #(.SW(STS_W)) u_sts (
        .clk, .rst_n, .set_vec, .clr_vec(sts_clr), .sts_q(sts_word)
    );

    assign proc_state = state_q;

    // R11: request and address hold until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(desc_ptr)));

    // R5: plain step at frame end
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_req && !wrap_req) |=> desc_ptr == $past(desc_ptr) + AW'(DESC_BYTES));

    // R5: wrap to base after end-of-ring descriptor
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_req && wrap_req) |=> desc_ptr == $past(base_addr));

    // R8: arriving in Stopped raises the stopped flag
    p_stop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && $past(state_q) != ST_STOP) |-> sts_word[STS_RPS_BIT]);

endmodule

// File: tb/test_rxdma_proc_ctrl.sv
module test_rxdma_proc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_bit = 1'b0, rx_enable = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          frame_active = 1'b0, frame_done = 1'b0, poll_kick = 1'b0;
    logic          fetch_req;
    logic          fetch_ack = 1'b0, fetch_own = 1'b0, fetch_eor = 1'b0;
    logic [AW-1:0] desc_ptr;
    logic [2:0]    proc_state;
    logic [7:0]    sts_word;
    logic [7:0]    sts_clr = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    rxdma_proc_ctrl #(.AW(AW), .DESC_BYTES(16)) i_rxdma_proc_ctrl (
        .clk, .rst_n, .run_bit, .rx_enable, .base_addr, .frame_active,
        .frame_done, .poll_kick, .fetch_req, .fetch_ack, .fetch_own, .fetch_eor,
        .desc_ptr, .proc_state, .sts_word, .sts_clr
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #(CLK_PERIOD/4);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic ack_with(input logic own, input logic eor);
        fetch_ack = 1'b1; fetch_own = own; fetch_eor = eor;
        tick();
        fetch_ack = 1'b0; fetch_own = 1'b0; fetch_eor = 1'b0;
    endtask

    task automatic t_reset;
        tick(2);
        chk("R1 state", 32'(proc_state), 0);
        chk("R1 ptr", desc_ptr, 0);
        chk("R1 status", 32'(sts_word), 0);
        chk("R1 req", 32'(fetch_req), 0);
    endtask

    task automatic t_first_start;
        base_addr = 32'h1000;
        run_bit   = 1'b1;
        tick();
        chk("R2 state", 32'(proc_state), 1);
        chk("R2 req", 32'(fetch_req), 1);
        chk("R2 ptr=base", desc_ptr, 32'h1000);
        tick(2);
        chk("R11 req held", 32'(fetch_req), 1);
        chk("R11 addr held", desc_ptr, 32'h1000);
        ack_with(1'b1, 1'b0);
        chk("R5 owned->wait", 32'(proc_state), 2);
    endtask

    task automatic t_deferred_stop;
        frame_active = 1'b1;
        run_bit      = 1'b0;
        tick(3);
        chk("R6 held mid-frame", 32'(proc_state), 2);
        chk("R6 no stop flag", 32'(sts_word[1]), 0);
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0; frame_active = 1'b0;
        chk("R6 stopped at end", 32'(proc_state), 0);
        chk("R6 kept next ptr", desc_ptr, 32'h1010);
        chk("R8 stop flag", 32'(sts_word[1]), 1);
    endtask

    task automatic t_restart_refuse;
        base_addr = 32'h2000;
        sts_clr   = 8'h02;
        tick();
        sts_clr   = 8'h00;
        chk("R10 w1c", 32'(sts_word[1]), 0);
        run_bit = 1'b1;
        tick();
        chk("R3 state", 32'(proc_state), 1);
        chk("R3 resume ptr", desc_ptr, 32'h1010);
        ack_with(1'b0, 1'b0);
        chk("R4 suspended", 32'(proc_state), 4);
        chk("R4 bit7", 32'(sts_word[7]), 1);
    endtask

    task automatic t_suspend_kick;
        rx_enable = 1'b1;
        run_bit   = 1'b0;
        tick(2);
        chk("R7 no stop rxen", 32'(proc_state), 4);
        chk("R7 no stop flag", 32'(sts_word[1]), 0);
        run_bit = 1'b1;
        tick();
        chk("R7 start ignored", 32'(proc_state), 4);
        rx_enable = 1'b0;
        poll_kick = 1'b1;
        tick();
        poll_kick = 1'b0;
        chk("R9 refetch state", 32'(proc_state), 1);
        chk("R9 same ptr", desc_ptr, 32'h1010);
        ack_with(1'b1, 1'b1);
        chk("R9 owned now", 32'(proc_state), 2);
        frame_active = 1'b1; frame_done = 1'b1;
        tick();
        frame_active = 1'b0; frame_done = 1'b0;
        chk("R5 wrap ptr", desc_ptr, 32'h2000);
        chk("R5 back to fetch", 32'(proc_state), 1);
        ack_with(1'b1, 1'b0);
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        chk("R5 step ptr", desc_ptr, 32'h2010);
    endtask

    task automatic t_set_wins;
        sts_clr = 8'h80;
        tick();
        sts_clr = 8'h00;
        chk("R10 bit7 cleared", 32'(sts_word[7]), 0);
        sts_clr = 8'h80;
        ack_with(1'b0, 1'b0);
        sts_clr = 8'h00;
        chk("R10 set wins", 32'(sts_word[7]), 1);
        chk("R4 suspended again", 32'(proc_state), 4);
    endtask

    task automatic t_stop_from_susp;
        run_bit = 1'b0;
        tick();
        chk("R8 stop from susp", 32'(proc_state), 0);
        chk("R8 flag", 32'(sts_word[1]), 1);
        chk("R8 ptr unchanged", desc_ptr, 32'h2010);
    endtask

    initial begin
        tick();
        rst_n = 1'b1;
        t_reset();
        t_first_start();
        t_deferred_stop();
        t_restart_refuse();
        t_suspend_kick();
        t_set_wins();
        t_stop_from_susp();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule